// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Four-Word Line Fill

This block is a virtually addressed read cache for a CPU's instructions and data. By default it holds 32 KB as 2048 lines of 16 bytes each. Each line has exactly one place it can live. A separate key store keeps an 18-bit address key and a valid bit for every line. A read request is latched, and then the key at the indexed line is compared against the upper address bits. If the key matches, the line is valid and the address translation unit reports success or is switched off, the addressed 32-bit word is returned on the next cycle.

When the key does not match, the block runs a burst of four long-word reads on its memory bus, starting at the line base and going up in address order. It assembles the line and writes the data, the key and the valid bit together when the fourth word arrives. In the same cycle it returns the requested word to the CPU. The block accepts no new request while a lookup or fill is in progress. A request whose translation is refused is answered with a deny pulse and leaves the cache and the bus untouched. A single invalidate input clears every valid bit, so that software can purge the cache after the translation tables or root pointers change.

Top module: `dm_line_cache`

## Requirements
- R1: After reset, `reqReady` is 1 and `respValid`, `respDeny` and `busReq` are 0. Every line is invalid, so the first read of any address misses.
- R2: Address bits [3:0] pick the byte in a line, bits [14:4] pick one of 2048 lines, and bits [31:15] form the key, zero-padded to 18 bits. `respData` is the 32-bit word selected by bits [3:2], and bits [1:0] have no effect.
- R3: A request is accepted on a clock edge where `reqValid` and `reqReady` are both 1. The qualifier (`xlatOk` OR `mmuOff`) is sampled on that same edge. On a hit with a true qualifier, `respValid` is 1 with the word for exactly one cycle after the next edge, and no bus read is made.
- R4: When neither `xlatOk` nor `mmuOff` is set at acceptance, `respDeny` pulses one cycle after the next edge. In that case `respValid` stays 0, no bus read is made and the cache contents are unchanged.
- R5: On a miss, `busReq` rises one cycle after the lookup. The block issues four reads at the line base plus 0, 4, 8 and 12, in that order. Each address is held until `busAck` is 1 on a clock edge.
- R6: On the edge that takes the fourth `busAck`, `busReq` falls and `respValid` pulses with the requested word. This holds even when the requested word is the one arriving on that edge.
- R7: After a fill, a read of any word of that line hits.
- R8: A read that maps to the same line under a different key misses and replaces the line. The earlier address then misses.
- R9: `reqReady` is 0 from acceptance until the response. A `reqValid` during that time is ignored and produces no response.
- R10: An `invalidate` sampled on a clock edge clears every valid bit. If it coincides with the fourth `busAck` of a fill, the filled line is left invalid, but the requested word is still returned.
- R11: `respValid` and `respDeny` are each one-cycle pulses, and only one of them answers any one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| invalidate | input | 1 | Clears all valid bits |
| reqValid | input | 1 | CPU read request |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | 32 | Virtual byte address of the read |
| xlatOk | input | 1 | Translation unit reports success |
| mmuOff | input | 1 | Translation unit is disabled |
| respValid | output | 1 | Read data is valid this cycle |
| respDeny | output | 1 | Read refused, translation not satisfied |
| respData | output | 32 | Returned word |
| busReq | output | 1 | Fill read request on memory bus |
| busAddr | output | 32 | Long-word address of the fill read |
| busAck | input | 1 | Bus returns data this cycle |
| busData | input | 32 | Bus read data |

## Verification
A hit or a deny is due exactly one clock after the accepting edge. A miss is due four bus beats later: with an acknowledge delay of d idle cycles per beat, that is 1 + 4·(d+1) cycles after acceptance. The bench drives inputs on the falling edge and counts falling edges from the one after acceptance. It requires the response on the exact count and then checks that nothing further arrives during three quiet cycles. The bus responder logs every acknowledged address on the falling edge, while the address is stable. This lets each scenario compare the number of beats and their order against the line base of the request.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int WORD_BITS  = 32;
  localparam int LINE_WORDS = 4;
  localparam int WIDX_W     = $clog2(LINE_WORDS);
  localparam int OFF_W      = WIDX_W + 2;
  localparam int LINE_BITS  = WORD_BITS * LINE_WORDS;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL
  } ctlState_t;

  typedef struct packed {
    logic              capReq;
    logic              wordWr;
    logic              lineWr;
    logic              loadHit;
    logic              loadFill;
    logic [WIDX_W-1:0] wordIdx;
  } dpStrobe_t;
endpackage

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       lookHit,
  input  logic       lookQual,
  input  logic       busAck,
  output logic       reqReady,
  output logic       respValid,
  output logic       respDeny,
  output logic       busReq,
  output dpStrobe_t  strobe
);
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(LINE_WORDS - 1);

  ctlState_t         state;
  logic [WIDX_W-1:0] wordCnt;

  assign reqReady = (state == ST_IDLE);
  assign busReq   = (state == ST_FILL);

  always_comb begin
    strobe          = '0;
    strobe.wordIdx  = wordCnt;
    strobe.capReq   = (state == ST_IDLE) && reqValid;
    strobe.loadHit  = (state == ST_LOOK) && lookQual && lookHit;
    strobe.wordWr   = (state == ST_FILL) && busAck;
    strobe.lineWr   = (state == ST_FILL) && busAck && (wordCnt == LAST_WORD);
    strobe.loadFill = strobe.lineWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wordCnt   <= '0;
      respValid <= 1'b0;
      respDeny  <= 1'b0;
    end else begin
      respValid <= 1'b0;
      respDeny  <= 1'b0;
      unique case (state)
        ST_IDLE: if (reqValid) state <= ST_LOOK;
        ST_LOOK: begin
          if (!lookQual) begin
            respDeny <= 1'b1;
            state    <= ST_IDLE;
          end else if (lookHit) begin
            respValid <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            wordCnt <= '0;
            state   <= ST_FILL;
          end
        end
        ST_FILL: if (busAck) begin
          if (wordCnt == LAST_WORD) begin
            respValid <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            wordCnt <= wordCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: each answer lasts a single cycle
  a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);
  a_r11_deny_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respDeny |=> !respDeny && !respValid);
endmodule

// File: rtl/dmc_dpath.sv
module dmc_dpath
  import dmc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 2048,
  parameter int KEY_W     = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 invalidate,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 xlatOk,
  input  logic                 mmuOff,
  input  logic [WORD_BITS-1:0] busData,
  input  dpStrobe_t            strobe,
  output logic                 lookHit,
  output logic                 lookQual,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [WORD_BITS-1:0] respData
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(LINE_WORDS - 1);

  logic [ADDR_W-1:2]    curAddr;
  logic                 curQual;
  logic [WORD_BITS-1:0] fillBuf [LINE_WORDS];
  logic [LINE_BITS-1:0] dataMem [NUM_LINES];
  logic [KEY_W-1:0]     keyMem  [NUM_LINES];
  logic [NUM_LINES-1:0] validBits;

  logic                 unusedByteSel;
  assign unusedByteSel = ^reqAddr[1:0];

  logic [IDX_W-1:0]     curIdx;
  logic [TAG_W-1:0]     curTag;
  logic [KEY_W-1:0]     curKey;
  logic [WIDX_W-1:0]    curWord;
  logic [LINE_BITS-1:0] newLine;
  logic [LINE_BITS-1:0] hitLine;

  assign curWord = curAddr[OFF_W-1:2];
  assign curIdx  = curAddr[OFF_W+IDX_W-1:OFF_W];
  assign curTag  = curAddr[ADDR_W-1:OFF_W+IDX_W];
  assign curKey  = KEY_W'(curTag);
  assign hitLine = dataMem[curIdx];

  assign lookHit  = validBits[curIdx] && (keyMem[curIdx] == curKey);
  assign lookQual = curQual;
  assign busAddr  = {curAddr[ADDR_W-1:OFF_W], strobe.wordIdx, 2'b00};

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_line
    if (w == LINE_WORDS - 1) begin : g_last
      assign newLine[w*WORD_BITS +: WORD_BITS] = busData;
    end else begin : g_buf
      assign newLine[w*WORD_BITS +: WORD_BITS] = fillBuf[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      curQual <= 1'b0;
    end else if (strobe.capReq) begin
      curAddr <= reqAddr[ADDR_W-1:2];
      curQual <= xlatOk | mmuOff;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wordWr) fillBuf[strobe.wordIdx] <= busData;
  end

  always_ff @(posedge clk) begin
    if (strobe.lineWr) begin
      dataMem[curIdx] <= newLine;
      keyMem[curIdx]  <= curKey;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                validBits <= '0;
    else if (invalidate)      validBits <= '0;
    else if (strobe.lineWr)   validBits[curIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respData <= '0;
    end else if (strobe.loadHit) begin
      respData <= hitLine[curWord*WORD_BITS +: WORD_BITS];
    end else if (strobe.loadFill) begin
      respData <= (curWord == LAST_WORD) ? busData : fillBuf[curWord];
    end
  end

  // R10: nothing can hit in the cycle after an invalidate
  a_r10_purge_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    invalidate |=> !lookHit);
endmodule

// File: rtl/dm_line_cache.sv
module dm_line_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 2048,
  parameter int KEY_W     = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              invalidate,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              xlatOk,
  input  logic              mmuOff,
  output logic              respValid,
  output logic              respDeny,
  output logic [31:0]       respData,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busAck,
  input  logic [31:0]       busData
);
  dpStrobe_t strobe;
  logic      lookHit;
  logic      lookQual;

  dmc_ctrl u_ctrl (
    .clk, .rstN, .reqValid, .lookHit, .lookQual, .busAck,
    .reqReady, .respValid, .respDeny, .busReq, .strobe
  );

  dmc_dpath #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .KEY_W(KEY_W)) u_dpath (
    .clk, .rstN, .invalidate, .reqAddr, .xlatOk, .mmuOff, .busData,
    .strobe, .lookHit, .lookQual, .busAddr, .respData
  );

  // R3: the cycle after acceptance is the lookup, never a bus beat
  a_r3_lookup_first: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !busReq && !respValid && !respDeny);
  // R5: a fill starts at the line base
  a_r5_start_at_base: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> busAddr[OFF_W-1:0] == '0);
  // R5: the address holds until it is acknowledged
  a_r5_hold_addr: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr));
  // R5: beats ascend by one long word
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck && (busAddr[OFF_W-1:2] != WIDX_W'(LINE_WORDS - 1))
    |=> busReq && (busAddr[OFF_W-1:2] == WIDX_W'($past(busAddr[OFF_W-1:2]) + 1'b1)));
  // R6: the last beat ends the fill and answers the CPU
  a_r6_done_on_last: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck && (busAddr[OFF_W-1:2] == WIDX_W'(LINE_WORDS - 1))
    |=> respValid && !busReq);
  // R9: no acceptance while the bus is busy
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !reqReady);
endmodule

// File: tb/tb_dm_line_cache.sv
`timescale 1ns/1ps
module tb_dm_line_cache;
  logic        clk = 1'b0;
  logic        rstN;
  logic        invTask, invResp, invalidate;
  logic        reqValid, reqReady;
  logic [31:0] reqAddr;
  logic        xlatOk, mmuOff;
  logic        respValid, respDeny;
  logic [31:0] respData;
  logic        busReq, busAck;
  logic [31:0] busAddr, busData;

  int          vecCount = 0;
  int          errCount = 0;
  int          ackDelay = 0;
  bit          invOnLast = 0;
  bit          finished = 0;
  logic [31:0] busLog [256];
  int          logCount = 0;

  assign invalidate = invTask | invResp;

  always #2.5 clk = ~clk;

  dm_line_cache dut (
    .clk, .rstN, .invalidate, .reqValid, .reqReady, .reqAddr, .xlatOk, .mmuOff,
    .respValid, .respDeny, .respData, .busReq, .busAddr, .busAck, .busData
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A3C_96E1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bus responder: acknowledges after ackDelay idle cycles, logs addresses
  initial begin
    int waitCnt = 0;
    busAck = 0; busData = '0; invResp = 0;
    forever begin
      @(negedge clk);
      if (busReq && waitCnt == ackDelay) begin
        busAck  = 1;
        busData = memWord(busAddr);
        busLog[logCount % 256] = busAddr;
        invResp = invOnLast && (busAddr[3:2] == 2'd3);
        logCount++;
        waitCnt = 0;
      end else begin
        busAck  = 0;
        invResp = 0;
        waitCnt = busReq ? waitCnt + 1 : 0;
      end
    end
  end

  // kind: 0 hit, 1 miss, 2 deny
  task automatic doRead(input logic [31:0] a, input bit xok, input bit moff,
                        input int kind, input string req, input bit poke);
    int n = 0;
    int startLog;
    int expLat;
    expLat = (kind == 1) ? 1 + 4 * (ackDelay + 1) : 1;
    @(negedge clk);
    startLog = logCount;
    check(reqReady === 1'b1, req, "ready before request", {31'd0, reqReady}, 32'd1);
    reqValid = 1; reqAddr = a; xlatOk = xok; mmuOff = moff;
    @(negedge clk);
    reqValid = 0;
    check(reqReady === 1'b0, "R9", "ready low after accept", {31'd0, reqReady}, 32'd0);
    while (n < 200) begin
      @(negedge clk);
      n++;
      if (reqValid) reqValid = 0;
      if (respValid || respDeny) break;
      if (poke && n == 2) begin
        check(reqReady === 1'b0, "R9", "ready low during fill", {31'd0, reqReady}, 32'd0);
        reqValid = 1; reqAddr = a ^ 32'h0000_8000;
      end
    end
    check(n == expLat, req, "response latency", n, expLat);
    if (kind == 2) begin
      check(respDeny === 1'b1 && respValid === 1'b0, "R4", "deny pulse",
            {30'd0, respDeny, respValid}, 32'd2);
    end else begin
      check(respValid === 1'b1 && respDeny === 1'b0, req, "valid pulse",
            {30'd0, respDeny, respValid}, 32'd1);
      check(respData === memWord(a), req, "data", respData, memWord(a));
    end
    if (kind == 1) begin
      check(logCount - startLog == 4, "R5", "beat count", logCount - startLog, 4);
      for (int i = 0; i < 4; i++) begin
        logic [31:0] expA = {a[31:4], 4'h0} + 32'(4 * i);
        check(busLog[(startLog + i) % 256] === expA, "R5", "beat address",
              busLog[(startLog + i) % 256], expA);
      end
    end else begin
      check(logCount == startLog, req, "no bus reads", logCount - startLog, 0);
    end
    for (int q = 0; q < 3; q++) begin
      @(negedge clk);
      check(!respValid && !respDeny && !busReq, "R11", "quiet after answer",
            {29'd0, busReq, respDeny, respValid}, 32'd0);
    end
  endtask

  task automatic testReset();
    check(reqReady === 1'b1, "R1", "reset ready", {31'd0, reqReady}, 32'd1);
    check(respValid === 1'b0 && respDeny === 1'b0 && busReq === 1'b0, "R1",
          "reset outputs idle", {29'd0, busReq, respDeny, respValid}, 32'd0);
    doRead(32'h0000_1234, 1, 0, 1, "R1", 0);
  endtask

  task automatic testHitsAndOffsets();
    doRead(32'h0000_1230, 1, 0, 0, "R7", 0);
    doRead(32'h0000_123C, 1, 0, 0, "R7", 0);
    doRead(32'h0000_1235, 1, 0, 0, "R2", 0);
    doRead(32'h0000_204C, 1, 0, 1, "R6", 0);
    doRead(32'h0000_2040, 1, 0, 0, "R3", 0);
    doRead(32'hFFFF_FFF0, 1, 0, 1, "R2", 0);
    doRead(32'hFFFF_FFF8, 1, 0, 0, "R2", 0);
  endtask

  task automatic testDeny();
    doRead(32'h0000_1230, 0, 0, 2, "R4", 0);
    doRead(32'h0000_1238, 0, 1, 0, "R3", 0);
    doRead(32'h0000_3000, 0, 0, 2, "R4", 0);
    doRead(32'h0000_3000, 1, 0, 1, "R4", 0);
  endtask

  task automatic testConflict();
    doRead(32'h0001_1234, 1, 0, 1, "R8", 0);
    doRead(32'h0001_1230, 1, 0, 0, "R8", 0);
    doRead(32'h0000_1234, 1, 0, 1, "R8", 0);
  endtask

  task automatic testBusyIgnore();
    ackDelay = 2;
    doRead(32'h0004_5678, 1, 0, 1, "R9", 1);
    ackDelay = 0;
    doRead(32'h0004_5674, 1, 0, 0, "R9", 0);
  endtask

  task automatic testInvalidate();
    doRead(32'h0000_5670, 1, 0, 1, "R10", 0);
    doRead(32'h0000_5670, 1, 0, 0, "R10", 0);
    @(negedge clk); invTask = 1;
    @(negedge clk); invTask = 0;
    doRead(32'h0000_5670, 1, 0, 1, "R10", 0);
    invOnLast = 1;
    doRead(32'h0000_6A04, 1, 0, 1, "R10", 0);
    invOnLast = 0;
    doRead(32'h0000_6A04, 1, 0, 1, "R10", 0);
  endtask

  initial begin
    rstN = 0; invTask = 0; reqValid = 0; reqAddr = '0; xlatOk = 0; mmuOff = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testHitsAndOffsets();
    testDeny();
    testConflict();
    testBusyIgnore();
    testInvalidate();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vecCount++;
      errCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end
endmodule